// File: doc/BRIEF.md
# Late-Write Burst Memory Front End

This block is the synchronous front end of an on-chip burst memory. On each rising clock edge it captures an address together with three controls: load a new address, continue the current burst, and choose one or two words per cycle. An internal two-bit counter walks the low address bits through a burst of up to four words. The walk runs in linear order (wrapping add) or in interleaved order (XOR with the step count), and the order is fixed when the address is loaded.

Writes are late. The data for a write address arrives on the data inputs one cycle after that address. It is parked in a one-entry write buffer and committed to the storage array later. A read that asks for an address still held in the buffer receives the buffered data through an address comparator (bypass). Read data comes out of registers two cycles after the address is captured, with a valid flag. There is no output enable: the outputs are qualified only by the read pipeline. Double rate is carried as two word lanes per cycle, and an outside pad serializer is expected to split those lanes across the two clock phases.

Top module: `lwb_sram`

## Requirements
- R1: While reset is active, and after it is released, `rvalid` and `rdual` are low and the write buffer is empty. A burst-continue (`adv`) with no address loaded since reset starts no access.
- R2: With `ld` high, the address, `wr`, `ddr` and `lin` are captured on the rising edge. For a read, the first word is on `rd0` with `rvalid` high from the second rising edge after that capture.
- R3: With `ld` low and `adv` high, the next access of the burst is issued. The upper address bits stay fixed, and the step count advances by 1 in single-word mode or by 2 in two-word mode, modulo 4. `ld` wins over `adv`. With both low, the cycle is idle, so a burst may stop after any number of words.
- R4: With `lin` high, the low two address bits of step k are (start + k) mod 4.
- R5: With `lin` low, the low two address bits of step k are start XOR k.
- R6: The write data for a write access is taken from `wd0` (and `wd1`) on the rising edge one cycle after the edge that captured its address. At any other edge the data inputs are ignored.
- R7: With `ddr` high, each access moves two words: `rd0`/`wd0` carry step k and `rd1`/`wd1` carry step k+1, and `rdual` is high with `rvalid`. In single-word mode `rd1` reads as zero.
- R8: A read of an address held in the write buffer returns the buffered data, not the array contents.
- R9: The buffered write is committed to the array on an edge where new write data arrives or the command stage is idle. While reads follow one another, the buffer keeps its entry.
- R10: Reset discards a write that is still in the buffer. A later read of that address returns the value the array held before.
- R11: Write and idle cycles never raise `rvalid` two cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld | input | 1 | Load a new external address and start an access |
| adv | input | 1 | Continue the current burst |
| wr | input | 1 | Access is a write (taken with `ld`) |
| ddr | input | 1 | Two words per cycle (taken with `ld`) |
| lin | input | 1 | Linear burst order when high, interleaved when low (taken with `ld`) |
| addr | input | AW | Word address |
| wd0 | input | DW | Write data, first word of the cycle |
| wd1 | input | DW | Write data, second word in two-word mode |
| rd0 | output | DW | Read data, first word |
| rd1 | output | DW | Read data, second word, zero in single-word mode |
| rvalid | output | 1 | Read data on `rd0` is valid |
| rdual | output | 1 | Read data on `rd1` is also valid |

## Verification
Two things can happen on the same clock edge. The buffered write can be committed to the array, and a read can sample the array at the same address and need the value that is only now being committed. The bench provokes this with back-to-back writes followed at once by reads of both addresses, and with a write followed by a string of reads that hold the entry in the buffer. A reference array in the bench is updated in the cycle the late data is driven, so each read is judged against the newest write no matter where the data physically sits. A reset placed between data capture and commit shows that the entry is dropped and the older array value returns.

// File: rtl/lwb_pkg.sv
package lwb_pkg;
  // low address bits of burst step k, from the start offset
  function automatic logic [1:0] lwb_ofs(input logic lin, input logic [1:0] start,
                                         input logic [1:0] k);
    return lin ? 2'(start + k) : (start ^ k);
  endfunction
endpackage

// File: rtl/lwb_burst.sv
module lwb_burst import lwb_pkg::*; #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic          adv,
  input  logic          wr,
  input  logic          ddr,
  input  logic          lin,
  input  logic [AW-1:0] addr,
  output logic          c_v,
  output logic          c_wr,
  output logic          c_ddr,
  output logic [AW-1:0] c_a0,
  output logic [AW-1:0] c_a1
);
  logic          act, n_act, go;
  logic [AW-1:0] base, n_base;
  logic          m_wr, m_ddr, m_lin, n_wr, n_ddr, n_lin;
  logic [1:0]    step, n_step, n_step1, o0, o1;

  always_comb begin
    n_act  = act;
    n_base = base;
    n_wr   = m_wr;
    n_ddr  = m_ddr;
    n_lin  = m_lin;
    n_step = step;
    go     = 1'b0;
    if (ld) begin
      n_act  = 1'b1;
      n_base = addr;
      n_wr   = wr;
      n_ddr  = ddr;
      n_lin  = lin;
      n_step = 2'd0;
      go     = 1'b1;
    end else if (adv && act) begin
      n_step = step + (m_ddr ? 2'd2 : 2'd1);
      go     = 1'b1;
    end
    n_step1 = n_step + 2'd1;
    o0 = lwb_ofs(n_lin, n_base[1:0], n_step);
    o1 = lwb_ofs(n_lin, n_base[1:0], n_step1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0;
      c_v <= 1'b0;
    end else begin
      act <= n_act;
      c_v <= go;
    end
  end

  always_ff @(posedge clk) begin
    if (ld) begin
      base  <= n_base;
      m_wr  <= n_wr;
      m_ddr <= n_ddr;
      m_lin <= n_lin;
    end
    if (go) begin
      step <= n_step;
      c_a0 <= {n_base[AW-1:2], o0};
      c_a1 <= {n_base[AW-1:2], o1};
    end
  end

  assign c_wr  = m_wr;
  assign c_ddr = m_ddr;
endmodule

// File: rtl/lwb_wbuf.sv
module lwb_wbuf #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          c_v,
  input  logic          c_wr,
  input  logic          c_ddr,
  input  logic [AW-1:0] c_a0,
  input  logic [AW-1:0] c_a1,
  input  logic [DW-1:0] wd0,
  input  logic [DW-1:0] wd1,
  output logic          b_v,
  output logic          b_ddr,
  output logic [AW-1:0] b_a0,
  output logic [AW-1:0] b_a1,
  output logic [DW-1:0] b_d0,
  output logic [DW-1:0] b_d1,
  output logic          we0,
  output logic          we1
);
  logic cap, commit, n_v;

  always_comb begin
    cap    = c_v && c_wr;
    commit = b_v && !(c_v && !c_wr);
    n_v    = cap ? 1'b1 : (commit ? 1'b0 : b_v);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) b_v <= 1'b0;
    else        b_v <= n_v;
  end

  always_ff @(posedge clk) begin
    if (cap) begin
      b_ddr <= c_ddr;
      b_a0  <= c_a0;
      b_a1  <= c_a1;
      b_d0  <= wd0;
      b_d1  <= wd1;
    end
  end

  assign we0 = commit;
  assign we1 = commit && b_ddr;
endmodule

// File: rtl/lwb_array.sv
module lwb_array #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we0,
  input  logic          we1,
  input  logic [AW-1:0] wa0,
  input  logic [AW-1:0] wa1,
  input  logic [DW-1:0] wd0,
  input  logic [DW-1:0] wd1,
  input  logic [AW-1:0] ra0,
  input  logic [AW-1:0] ra1,
  output logic [DW-1:0] q0,
  output logic [DW-1:0] q1
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we0) mem[wa0] <= wd0;
    if (we1) mem[wa1] <= wd1;
  end

  assign q0 = mem[ra0];
  assign q1 = mem[ra1];
endmodule

// File: rtl/lwb_rdpipe.sv
module lwb_rdpipe #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          c_v,
  input  logic          c_wr,
  input  logic          c_ddr,
  input  logic [AW-1:0] c_a0,
  input  logic [AW-1:0] c_a1,
  input  logic          b_v,
  input  logic          b_ddr,
  input  logic [AW-1:0] b_a0,
  input  logic [AW-1:0] b_a1,
  input  logic [DW-1:0] b_d0,
  input  logic [DW-1:0] b_d1,
  input  logic [DW-1:0] q0,
  input  logic [DW-1:0] q1,
  output logic [AW-1:0] ra0,
  output logic [AW-1:0] ra1,
  output logic          rvalid,
  output logic          rdual,
  output logic [DW-1:0] rd0,
  output logic [DW-1:0] rd1
);
  logic          p_rd, p_ddr;
  logic [AW-1:0] p_a0, p_a1;
  logic [DW-1:0] w0, w1;

  always_comb begin
    w0 = q0;
    if (b_v && p_a0 == b_a0)               w0 = b_d0;
    else if (b_v && b_ddr && p_a0 == b_a1) w0 = b_d1;
    w1 = q1;
    if (b_v && p_a1 == b_a0)               w1 = b_d0;
    else if (b_v && b_ddr && p_a1 == b_a1) w1 = b_d1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_rd   <= 1'b0;
      rvalid <= 1'b0;
      rdual  <= 1'b0;
    end else begin
      p_rd   <= c_v && !c_wr;
      rvalid <= p_rd;
      rdual  <= p_rd && p_ddr;
    end
  end

  always_ff @(posedge clk) begin
    if (c_v && !c_wr) begin
      p_ddr <= c_ddr;
      p_a0  <= c_a0;
      p_a1  <= c_a1;
    end
    if (p_rd) begin
      rd0 <= w0;
      rd1 <= p_ddr ? w1 : '0;
    end
  end

  assign ra0 = p_a0;
  assign ra1 = p_a1;
endmodule

// File: rtl/lwb_sram.sv
module lwb_sram #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic          adv,
  input  logic          wr,
  input  logic          ddr,
  input  logic          lin,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wd0,
  input  logic [DW-1:0] wd1,
  output logic [DW-1:0] rd0,
  output logic [DW-1:0] rd1,
  output logic          rvalid,
  output logic          rdual
);
  logic          r_meta, rst_i;
  logic          c_v, c_wr, c_ddr;
  logic [AW-1:0] c_a0, c_a1;
  logic          b_v, b_ddr, we0, we1;
  logic [AW-1:0] b_a0, b_a1, ra0, ra1;
  logic [DW-1:0] b_d0, b_d1, q0, q1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {r_meta, rst_i} <= 2'b00;
    else        {r_meta, rst_i} <= {1'b1, r_meta};
  end

  lwb_burst #(.AW(AW)) u_burst (
    .clk(clk), .rst_n(rst_i), .ld(ld), .adv(adv), .wr(wr), .ddr(ddr), .lin(lin),
    .addr(addr), .c_v(c_v), .c_wr(c_wr), .c_ddr(c_ddr), .c_a0(c_a0), .c_a1(c_a1)
  );

  lwb_wbuf #(.AW(AW), .DW(DW)) u_wbuf (
    .clk(clk), .rst_n(rst_i), .c_v(c_v), .c_wr(c_wr), .c_ddr(c_ddr),
    .c_a0(c_a0), .c_a1(c_a1), .wd0(wd0), .wd1(wd1),
    .b_v(b_v), .b_ddr(b_ddr), .b_a0(b_a0), .b_a1(b_a1), .b_d0(b_d0), .b_d1(b_d1),
    .we0(we0), .we1(we1)
  );

  lwb_array #(.AW(AW), .DW(DW)) u_array (
    .clk(clk), .we0(we0), .we1(we1), .wa0(b_a0), .wa1(b_a1), .wd0(b_d0), .wd1(b_d1),
    .ra0(ra0), .ra1(ra1), .q0(q0), .q1(q1)
  );

  lwb_rdpipe #(.AW(AW), .DW(DW)) u_rdpipe (
    .clk(clk), .rst_n(rst_i), .c_v(c_v), .c_wr(c_wr), .c_ddr(c_ddr),
    .c_a0(c_a0), .c_a1(c_a1), .b_v(b_v), .b_ddr(b_ddr), .b_a0(b_a0), .b_a1(b_a1),
    .b_d0(b_d0), .b_d1(b_d1), .q0(q0), .q1(q1), .ra0(ra0), .ra1(ra1),
    .rvalid(rvalid), .rdual(rdual), .rd0(rd0), .rd1(rd1)
  );
endmodule

// File: rtl/lwb_sram_chk.sv
module lwb_sram_chk #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_i,
  input logic          c_v,
  input logic          c_wr,
  input logic          b_v,
  input logic [AW-1:0] b_a0,
  input logic          rvalid,
  input logic          rdual,
  input logic [DW-1:0] rd1
);
  // R2: an issued read shows up two edges later
  a_r2_read_latency: assert property (@(posedge clk) disable iff (!rst_i)
    (c_v && !c_wr) |-> ##2 rvalid);

  // R11: no valid data two edges after a write or idle slot
  a_r11_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_i)
    !(c_v && !c_wr) |-> ##2 !rvalid);

  // R6: a write slot fills the buffer on the following edge
  a_r6_late_capture: assert property (@(posedge clk) disable iff (!rst_i)
    (c_v && c_wr) |=> b_v);

  // R9: reads in flight keep the buffered entry untouched
  a_r9_hold_on_read: assert property (@(posedge clk) disable iff (!rst_i)
    (b_v && c_v && !c_wr) |=> (b_v && $stable(b_a0)));

  // R7: second lane is zero when only one word is valid
  a_r7_single_lane: assert property (@(posedge clk) disable iff (!rst_i)
    (rvalid && !rdual) |-> (rd1 == '0));

  // R10: reset leaves the buffer empty
  always @(posedge clk) begin
    if (!rst_i) begin
      a_r10_buffer_cleared: assert (!b_v);
    end
  end
endmodule

bind lwb_sram lwb_sram_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_i(rst_i), .c_v(c_v), .c_wr(c_wr), .b_v(b_v), .b_a0(b_a0),
  .rvalid(rvalid), .rdual(rdual), .rd1(rd1)
);

// File: tb/lwb_sram_test.sv
module lwb_sram_test;
  localparam int CLK_NS = 10;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic ld = 1'b0, adv = 1'b0, wr = 1'b0, ddr = 1'b0, lin = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wd0 = '0, wd1 = '0;
  logic [DW-1:0] rd0, rd1;
  logic rvalid, rdual;

  always #(CLK_NS/2) clk = ~clk;

  lwb_sram #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .ld(ld), .adv(adv), .wr(wr), .ddr(ddr), .lin(lin),
    .addr(addr), .wd0(wd0), .wd1(wd1), .rd0(rd0), .rd1(rd1),
    .rvalid(rvalid), .rdual(rdual)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [7:0] seed = 8'h00;
  logic [DW-1:0] mref [256];
  // bench burst model
  bit ba = 0, bw = 0, bd = 0, bl = 0;
  logic [7:0] bb = '0;
  logic [1:0] bs = '0;
  // pending late write
  bit pv = 0, pdd = 0;
  logic [7:0] pa0 = '0, pa1 = '0;
  // expectation pipe, index 2 is due now
  bit qv[3], qd[3];
  logic [DW-1:0] q0[3], q1[3];
  string qt[3];

  function automatic logic [DW-1:0] mk(input logic [7:0] a);
    return {seed, a};
  endfunction

  function automatic logic [1:0] ofs(input bit l, input logic [1:0] s, input logic [1:0] k);
    int v;
    if (l) v = (int'(s) + int'(k)) % 4;
    else   v = int'(s ^ k);
    return v[1:0];
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic clear_model();
    ba = 0; pv = 0;
    for (int i = 0; i < 3; i++) begin qv[i] = 0; qd[i] = 0; qt[i] = "R1"; end
  endtask

  task automatic step(input bit l, input bit a, input bit w, input bit d, input bit li,
                      input logic [7:0] ad, input string tag);
    logic [DW-1:0] x0, x1;
    logic [7:0] a0, a1;
    logic [1:0] s1;
    bit go;
    x0 = 16'hdead; x1 = 16'hbeef;
    if (pv) begin
      x0 = mk(pa0); mref[pa0] = x0;
      if (pdd) begin x1 = mk(pa1); mref[pa1] = x1; end
    end
    go = 0;
    if (l) begin ba = 1; bb = ad; bw = w; bd = d; bl = li; bs = 2'd0; go = 1; end
    else if (a && ba) begin bs = bs + (bd ? 2'd2 : 2'd1); go = 1; end
    s1 = bs + 2'd1;
    a0 = {bb[7:2], ofs(bl, bb[1:0], bs)};
    a1 = {bb[7:2], ofs(bl, bb[1:0], s1)};
    pv = go && bw; pdd = bd; pa0 = a0; pa1 = a1;
    for (int i = 2; i > 0; i--) begin
      qv[i] = qv[i-1]; qd[i] = qd[i-1]; q0[i] = q0[i-1]; q1[i] = q1[i-1]; qt[i] = qt[i-1];
    end
    qv[0] = go && !bw; qd[0] = go && !bw && bd;
    q0[0] = mref[a0]; q1[0] = bd ? mref[a1] : '0; qt[0] = tag;
    wd0 = x0; wd1 = x1;
    ld = l; adv = a; wr = w; ddr = d; lin = li; addr = ad;
    @(posedge clk);
    @(negedge clk);
    chk(qt[2], "rvalid", 32'(rvalid), 32'(qv[2]));
    chk(qt[2], "rdual", 32'(rdual), 32'(qd[2]));
    if (qv[2]) begin
      chk(qt[2], "rd0", 32'(rd0), 32'(q0[2]));
      chk(qt[2], "rd1", 32'(rd1), 32'(q1[2]));
    end
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 8'h00, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; ld = 0; adv = 0; wr = 0;
    clear_model();
    repeat (3) @(negedge clk);
    chk("R1", "rvalid in reset", 32'(rvalid), 32'd0);
    chk("R1", "rdual in reset", 32'(rdual), 32'd0);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "rvalid after release", 32'(rvalid), 32'd0);
    step(0, 1, 0, 0, 1, 8'h05, "R1");   // adv with no address loaded
    step(0, 1, 0, 0, 1, 8'h05, "R1");
    idle("R1"); idle("R1");
  endtask

  task automatic t_sdr_linear();
    seed = 8'h01;
    step(1, 0, 1, 0, 1, 8'h11, "R6/R11");
    step(0, 1, 1, 0, 1, 8'h00, "R6/R11");
    step(0, 1, 1, 0, 1, 8'h00, "R6/R11");
    step(0, 1, 1, 0, 1, 8'h00, "R6/R11");
    step(1, 0, 0, 0, 1, 8'h11, "R2/R4");
    step(0, 1, 0, 0, 1, 8'h00, "R3/R4");
    step(0, 1, 0, 0, 1, 8'h00, "R3/R4");
    step(0, 1, 0, 0, 1, 8'h00, "R3/R4");
    idle("R3"); idle("R3");
  endtask

  task automatic t_orders();
    step(1, 0, 0, 0, 0, 8'h12, "R5");
    step(0, 1, 0, 0, 0, 8'h00, "R5");
    step(0, 1, 0, 0, 0, 8'h00, "R5");
    step(0, 1, 0, 0, 0, 8'h00, "R5");
    step(1, 0, 0, 0, 1, 8'h13, "R4");   // wraps 3,0,1,2
    step(0, 1, 0, 0, 1, 8'h00, "R4");
    step(0, 1, 0, 0, 1, 8'h00, "R4");
    idle("R3");                          // short burst ends
    idle("R3"); idle("R3");
  endtask

  task automatic t_ddr();
    seed = 8'h02;
    step(1, 0, 1, 1, 0, 8'h21, "R7/R6");
    step(0, 1, 1, 1, 0, 8'h00, "R7/R6");
    idle("R7"); idle("R7");
    step(1, 0, 0, 1, 1, 8'h22, "R7");
    step(0, 1, 0, 1, 1, 8'h00, "R7");
    step(1, 0, 0, 1, 0, 8'h23, "R7/R5");
    step(0, 1, 0, 1, 0, 8'h00, "R7/R5");
    step(1, 0, 0, 0, 1, 8'h20, "R7");   // single-lane read, rd1 zero
    idle("R7"); idle("R7");
  endtask

  task automatic t_bypass();
    seed = 8'h50;
    step(1, 0, 1, 0, 1, 8'h40, "R8");
    step(1, 0, 0, 0, 1, 8'h40, "R8");
    step(1, 0, 0, 0, 1, 8'h40, "R8");
    step(1, 0, 0, 0, 1, 8'h40, "R8");
    idle("R8"); idle("R8");
    seed = 8'h60;
    step(1, 0, 1, 0, 1, 8'h44, "R9");
    step(1, 0, 1, 0, 1, 8'h48, "R9");
    step(1, 0, 0, 0, 1, 8'h44, "R9");
    step(1, 0, 0, 0, 1, 8'h48, "R9");
    idle("R9"); idle("R9");
    step(1, 0, 0, 0, 1, 8'h44, "R9");
    step(1, 0, 0, 0, 1, 8'h48, "R9");
    idle("R9"); idle("R9");
  endtask

  task automatic t_ld_wins();
    step(1, 0, 0, 0, 1, 8'h11, "R3");
    step(1, 1, 0, 0, 1, 8'h13, "R3");   // load beats continue
    step(0, 1, 0, 0, 1, 8'h00, "R3");
    idle("R3"); idle("R3");
  endtask

  task automatic t_drop();
    logic [DW-1:0] old;
    old = mref[8'h11];
    seed = 8'h70;
    step(1, 0, 1, 0, 1, 8'h11, "R10");
    step(1, 0, 0, 0, 1, 8'h12, "R10");  // late data enters buffer, read holds it
    do_reset();
    mref[8'h11] = old;                  // pending write is lost
    step(1, 0, 0, 0, 1, 8'h11, "R10");
    idle("R10"); idle("R10");
  endtask

  initial begin
    clear_model();
    #1 rst_n = 0;
    t_reset();
    t_sdr_linear();
    t_orders();
    t_ddr();
    t_bypass();
    t_ld_wins();
    t_drop();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_NS * 20000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule